// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits between the host side of an EEPROM and its write engine. Every qualified write cycle (address plus data byte, one clock wide) passes through it. The block sorts each write into exactly one of three results. It can forward the write to the array. It can absorb the write as part of a command. Or it can refuse the write while still telling the engine to start a dummy timed cycle, so that status polling looks the same as for a real write.

A three-write unlock code does two jobs. It turns protection on, and it also opens a page window in which the writes that follow reach the array even while protection is on. A six-write code turns protection off. Command writes must arrive within the byte-load window, measured in clock cycles. A longer pause, or any write that does not match the next expected code byte, drops the detector back to idle.

The protection flag has its own reset, which stands for the factory-fresh state of nonvolatile storage. The ordinary reset, which stands for a power cycle, does not touch the flag.

Top module: `sdp_guard`

## Requirements
- R1: After both resets, the protection flag `prot` is 0 and no outcome pulse is raised.
- R2: When unprotected and no command is in progress, a write that is not the first code byte gives `arr_we`=1 one cycle later, with `arr_addr`/`arr_data` equal to the written address and data.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 each give `cmd_eat`=1 one cycle later. `prot` reads 1 in the cycle the third write is absorbed.
- R4: When protected and outside an unlocked page, an ordinary write gives `rej_start`=1 and no `arr_we`.
- R5: When protected, the three-write unlock code followed by writes spaced within the window gives `arr_we` for each of those writes, including writes that look like code bytes. Once the window lapses, the next ordinary write is refused.
- R6: A pause of at most `TIMEOUT_CYC` idle cycles between two writes keeps a sequence alive. A pause of `TIMEOUT_CYC`+1 or more aborts it, and the late write is handled as an ordinary write.
- R7: A wrong address or data value at any step returns the detector to idle. That write is forwarded when unprotected and refused when protected.
- R8: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 are all absorbed, and `prot` reads 0 after the sixth.
- R9: Asserting `rst_n` alone leaves `prot` unchanged but discards any partial command sequence.
- R10: Every write gives exactly one outcome pulse one cycle later. Cycles without a write give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the detector (power cycle) |
| nv_rst_n | input | 1 | Active-low asynchronous reset of the protection flag (factory state) |
| wr_valid | input | 1 | One-cycle strobe of a qualified write |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data byte |
| arr_we | output | 1 | Pulse: forward the write to the array |
| arr_addr | output | AW | Address of the forwarded write |
| arr_data | output | 8 | Data of the forwarded write |
| cmd_eat | output | 1 | Pulse: write absorbed as command data |
| rej_start | output | 1 | Pulse: write refused, start a dummy timed cycle |
| prot | output | 1 | Protection flag |

## Verification
A detector stuck in the wrong state shows up on the very next write. It either absorbs a byte that should pass, or it forwards or refuses a byte that should be absorbed. The sweeps therefore break the code at every step, in both flag states, and look at the outcome one cycle later. A miscounted window shows only at its edge, so the pause sweep steps through every idle length around `TIMEOUT_CYC`. A flag that follows the wrong reset shows up as a refused or forwarded write after `rst_n` alone is pulsed.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_DIS3,
        ST_DIS4,
        ST_DIS5,
        ST_OPEN
    } sdp_state_e;

    typedef enum logic [1:0] {
        M_MISS,
        M_NEXT,
        M_ENABLE,
        M_DISABLE
    } match_e;

    localparam logic [7:0] CODE_LEAD   = 8'hAA;
    localparam logic [7:0] CODE_SECOND = 8'h55;
    localparam logic [7:0] CODE_LOCK   = 8'hA0;
    localparam logic [7:0] CODE_OFFPRE = 8'h80;
    localparam logic [7:0] CODE_OFFEND = 8'h20;
endpackage

// File: rtl/sdp_match.sv
module sdp_match
    import sdp_pkg::*;
#(
    parameter int AW = 15,
    parameter logic [AW-1:0] ADDR_P = 'h5555,
    parameter logic [AW-1:0] ADDR_Q = 'h2AAA
) (
    input  sdp_state_e    st,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    data,
    output match_e        res
);
    logic at_p;
    logic at_q;

    always_comb begin
        at_p = (addr == ADDR_P);
        at_q = (addr == ADDR_Q);
        res  = M_MISS;
        unique case (st)
            ST_IDLE, ST_DIS3: if (at_p && data == CODE_LEAD)   res = M_NEXT;
            ST_K1, ST_DIS4:   if (at_q && data == CODE_SECOND) res = M_NEXT;
            ST_K2: begin
                if (at_p && data == CODE_LOCK)        res = M_ENABLE;
                else if (at_p && data == CODE_OFFPRE) res = M_NEXT;
            end
            ST_DIS5:          if (at_p && data == CODE_OFFEND) res = M_DISABLE;
            default:          res = M_MISS;
        endcase
    end
endmodule

// File: rtl/sdp_gap_timer.sv
module sdp_gap_timer #(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    output logic expired
);
    localparam int GW = $clog2(TIMEOUT_CYC + 2);
    localparam logic [GW-1:0] SAT = GW'(TIMEOUT_CYC + 1);

    logic [GW-1:0] gap_d, gap_q;

    always_comb begin
        expired = (gap_q == SAT);
        if (wr)           gap_d = '0;
        else if (expired) gap_d = gap_q;
        else              gap_d = gap_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= SAT;
        else        gap_q <= gap_d;
    end

    // R6: a write always reopens the window for the next cycle
    p_fresh_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !expired);
endmodule

// File: rtl/sdp_nv_flag.sv
module sdp_nv_flag (
    input  logic clk,
    input  logic nv_rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set)      flag_d = 1'b1;
        else if (clr) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge nv_rst_n) begin
        if (!nv_rst_n) flag_q <= 1'b0;
        else           flag_q <= flag_d;
    end

    assign flag = flag_q;

    // R9: the stored flag moves only on a set or clear request
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!nv_rst_n)
        (!set && !clr) |=> $stable(flag));
    p_no_set_clr_r8: assert property (@(posedge clk) disable iff (!nv_rst_n)
        !(set && clr));
endmodule

// File: rtl/sdp_guard.sv
module sdp_guard
    import sdp_pkg::*;
#(
    parameter int AW = 15,
    parameter int TIMEOUT_CYC = 16,
    parameter logic [AW-1:0] CMD_ADDR_P = 'h5555,
    parameter logic [AW-1:0] CMD_ADDR_Q = 'h2AAA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nv_rst_n,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [7:0]    arr_data,
    output logic          cmd_eat,
    output logic          rej_start,
    output logic          prot
);
    typedef struct packed {
        sdp_state_e    st;
        logic          arr_we;
        logic          cmd_eat;
        logic          rej_start;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } regs_t;

    regs_t      r_d, r_q;
    sdp_state_e eff_st;
    match_e     res;
    logic       expired;
    logic       set_req, clr_req;

    function automatic sdp_state_e advance(input sdp_state_e s);
        case (s)
            ST_IDLE: return ST_K1;
            ST_K1:   return ST_K2;
            ST_K2:   return ST_DIS3;
            ST_DIS3: return ST_DIS4;
            ST_DIS4: return ST_DIS5;
            default: return ST_IDLE;
        endcase
    endfunction

    sdp_gap_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_gap (
        .clk(clk), .rst_n(rst_n), .wr(wr_valid), .expired(expired)
    );

    sdp_match #(.AW(AW), .ADDR_P(CMD_ADDR_P), .ADDR_Q(CMD_ADDR_Q)) u_match (
        .st(eff_st), .addr(wr_addr), .data(wr_data), .res(res)
    );

    sdp_nv_flag u_flag (
        .clk(clk), .nv_rst_n(nv_rst_n), .set(set_req), .clr(clr_req), .flag(prot)
    );

    always_comb begin
        eff_st      = expired ? ST_IDLE : r_q.st;
        r_d         = r_q;
        r_d.st      = eff_st;
        r_d.arr_we  = 1'b0;
        r_d.cmd_eat = 1'b0;
        r_d.rej_start = 1'b0;
        set_req     = 1'b0;
        clr_req     = 1'b0;
        if (wr_valid) begin
            if (eff_st == ST_OPEN) begin
                r_d.arr_we = 1'b1;
            end else begin
                unique case (res)
                    M_NEXT: begin
                        r_d.cmd_eat = 1'b1;
                        r_d.st      = advance(eff_st);
                    end
                    M_ENABLE: begin
                        r_d.cmd_eat = 1'b1;
                        r_d.st      = ST_OPEN;
                        set_req     = 1'b1;
                    end
                    M_DISABLE: begin
                        r_d.cmd_eat = 1'b1;
                        r_d.st      = ST_IDLE;
                        clr_req     = 1'b1;
                    end
                    default: begin
                        r_d.st        = ST_IDLE;
                        r_d.rej_start = prot;
                        r_d.arr_we    = !prot;
                    end
                endcase
            end
            if (r_d.arr_we) begin
                r_d.addr = wr_addr;
                r_d.data = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= ST_IDLE;
            r_q.arr_we    <= 1'b0;
            r_q.cmd_eat   <= 1'b0;
            r_q.rej_start <= 1'b0;
            r_q.addr      <= '0;
            r_q.data      <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign arr_we    = r_q.arr_we;
    assign arr_addr  = r_q.addr;
    assign arr_data  = r_q.data;
    assign cmd_eat   = r_q.cmd_eat;
    assign rej_start = r_q.rej_start;

    // R10: one outcome per write, none without a write
    p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        wr_valid |=> ($countones({arr_we, cmd_eat, rej_start}) == 1));
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        !wr_valid |=> !(arr_we || cmd_eat || rej_start));
    // R4: a protected ordinary write outside an open page is refused
    p_guarded_r4: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        (wr_valid && prot && eff_st == ST_IDLE && res == M_MISS) |=> (rej_start && !arr_we));
    // R3: protection rises only with an absorbed third unlock byte
    p_enable_r3: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        $rose(prot) |-> (cmd_eat && $past(wr_valid && r_q.st == ST_K2)));
    // R8: protection falls only with an absorbed final disable byte
    p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        $fell(prot) |-> (cmd_eat && $past(wr_valid && r_q.st == ST_DIS5)));
endmodule

// File: tb/sdp_guard_bench.sv
`timescale 1ns/1ps
module sdp_guard_bench;
    localparam int AW  = 15;
    localparam int TMO = 16;
    localparam logic [2:0] O_NONE = 3'b000;
    localparam logic [2:0] O_PASS = 3'b100;
    localparam logic [2:0] O_CMD  = 3'b010;
    localparam logic [2:0] O_REJ  = 3'b001;

    logic clk = 1'b0;
    logic rst_n, nv_rst_n, wr_valid;
    logic [AW-1:0] wr_addr;
    logic [7:0] wr_data;
    logic arr_we, cmd_eat, rej_start, prot;
    logic [AW-1:0] arr_addr;
    logic [7:0] arr_data;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sdp_guard #(.AW(AW), .TIMEOUT_CYC(TMO)) u_sdp_guard (
        .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_data(arr_data), .cmd_eat(cmd_eat), .rej_start(rej_start), .prot(prot)
    );

    function automatic logic [AW-1:0] seq_a(input int i);
        return (i == 1 || i == 4) ? AW'('h2AAA) : AW'('h5555);
    endfunction

    function automatic logic [7:0] seq_d(input int i);
        case (i)
            0, 3: return 8'hAA;
            1, 4: return 8'h55;
            2:    return 8'h80;
            default: return 8'h20;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [2:0] exp_o, input logic exp_p);
        checks++;
        if ({arr_we, cmd_eat, rej_start} !== exp_o || prot !== exp_p) begin
            fails++;
            $display("FAIL %s: outcome=%b prot=%b expected outcome=%b prot=%b",
                     tag, {arr_we, cmd_eat, rej_start}, prot, exp_o, exp_p);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock(input string tag, input logic p_before);
        wr(AW'('h5555), 8'hAA); chk(tag, O_CMD, p_before);
        wr(AW'('h2AAA), 8'h55); chk(tag, O_CMD, p_before);
        wr(AW'('h5555), 8'hA0); chk(tag, O_CMD, 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL R10: watchdog expired, actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; nv_rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
        idle(3);
        rst_n = 1'b1; nv_rst_n = 1'b1;
        idle(1);
        chk("R1 reset state", O_NONE, 1'b0);

        // R2: ordinary writes pass with their address and data
        for (int i = 0; i < 8; i++) begin
            logic [AW-1:0] a = AW'(i * 'h0913 + 3);
            logic [7:0] d = 8'(i * 37 + 5);
            wr(a, d);
            chk("R2 pass", O_PASS, 1'b0);
            checks++;
            if (arr_addr !== a || arr_data !== d) begin
                fails++;
                $display("FAIL R2: addr/data=%h/%h expected %h/%h", arr_addr, arr_data, a, d);
            end
        end
        idle(1);
        chk("R10 no write no outcome", O_NONE, 1'b0);

        // R7: break the code at each step while unprotected
        for (int s = 0; s < 6; s++) begin
            for (int k = 0; k < s; k++) begin
                wr(seq_a(k), seq_d(k));
                chk("R7 prefix", O_CMD, 1'b0);
            end
            wr(seq_a(s), seq_d(s) ^ 8'h01);
            chk("R7 unprotected miss", O_PASS, 1'b0);
            idle(TMO + 2);
        end

        // R3: enable
        unlock("R3 enable", 1'b0);
        idle(TMO + 2);

        // R4: protected ordinary writes refused
        for (int i = 0; i < 4; i++) begin
            wr(AW'(i * 'h1111 + 7), 8'(i + 1));
            chk("R4 refused", O_REJ, 1'b1);
        end

        // R7: break the code at each step while protected
        for (int s = 0; s < 6; s++) begin
            for (int k = 0; k < s; k++) begin
                wr(seq_a(k), seq_d(k));
                chk("R7 prefix protected", O_CMD, 1'b1);
            end
            wr(seq_a(s), seq_d(s) ^ 8'h01);
            chk("R7 protected miss", O_REJ, 1'b1);
            idle(TMO + 2);
        end

        // R5: unlocked page, including code-like bytes, then lapse
        unlock("R5 prefix", 1'b1);
        wr(AW'('h0040), 8'h11); chk("R5 page", O_PASS, 1'b1);
        idle(TMO);
        wr(AW'('h0041), 8'h22); chk("R5 page late edge", O_PASS, 1'b1);
        wr(AW'('h5555), 8'hAA); chk("R5 code-like data", O_PASS, 1'b1);
        idle(TMO + 1);
        wr(AW'('h0042), 8'h33); chk("R5 after lapse", O_REJ, 1'b1);

        // R6: pause sweep between first and second code byte
        for (int n = 0; n <= TMO + 3; n++) begin
            idle(TMO + 2);
            wr(AW'('h5555), 8'hAA); chk("R6 first", O_CMD, 1'b1);
            idle(n);
            wr(AW'('h2AAA), 8'h55);
            chk("R6 pause", (n <= TMO) ? O_CMD : O_REJ, 1'b1);
        end
        idle(TMO + 2);

        // R9: power-cycle reset keeps the flag, drops the partial code
        wr(AW'('h5555), 8'hAA); chk("R9 first", O_CMD, 1'b1);
        rst_n = 1'b0;
        idle(1);
        chk("R9 during reset", O_NONE, 1'b1);
        rst_n = 1'b1;
        wr(AW'('h2AAA), 8'h55); chk("R9 partial lost", O_REJ, 1'b1);
        idle(TMO + 2);

        // R8: disable
        for (int k = 0; k < 6; k++) begin
            wr(seq_a(k), seq_d(k));
            chk("R8 disable", O_CMD, (k == 5) ? 1'b0 : 1'b1);
        end
        wr(AW'('h0123), 8'h5A); chk("R8 writes pass again", O_PASS, 1'b0);
        for (int k = 0; k < 6; k++) begin
            wr(seq_a(k), seq_d(k));
            chk("R8 disable while off", O_CMD, 1'b0);
        end
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule